// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Unit

This block resolves read-after-write conflicts in a five-stage in-order integer pipeline. Two groups of comparisons run side by side. The first group belongs to the instruction now in execute: each of its two source register numbers is compared against the destination numbers and write enables held in the execute/memory and memory/writeback pipeline registers. For each ALU operand the block returns a 2-bit select code, so the operand mux can take the freshest copy of the value in place of the stale register-file read. The second group belongs to the instruction in decode. It is compared against a load that sits in decode/execute. When the decode instruction needs the value that load will return, the load data cannot reach execute in time, so the block asks for one stall cycle.

During that stall the program counter and the fetch/decode register keep their contents, and decode/execute is loaded with a bubble: the all-zero no-operation word, with every write and memory enable cleared. The load moves on to memory. In the next cycle it is one stage further along, and the normal writeback bypass delivers its data. The register file is taken to write in the first half of a cycle and read in the second. An instruction three slots behind its producer therefore reads the new value straight from the file, and only two bypass sources are needed.

The unit is purely combinational. It holds no state, and its outputs follow its inputs within the same cycle.

Top module: `hazard_fwd_unit`

## Requirements
- R1: An execute source register that is nonzero, and that matches the execute/memory destination while the execute/memory write enable is high, gives select code 2'b10 for that operand.
- R2: An execute source that is nonzero, does not meet the R1 condition, and matches the memory/writeback destination while that stage's write enable is high, gives select code 2'b01.
- R3: When both later stages match the same nonzero source with their write enables high, the execute/memory result wins and the code is 2'b10.
- R4: A source register number of 0 always gives code 2'b00, whatever the destinations and enables are.
- R5: A stage whose write enable is low is never a bypass source, even when its destination matches.
- R6: An operand whose source matches no enabled later stage gives code 2'b00, which selects the register-file value.
- R7: When the decode/execute register holds a load with a nonzero destination equal to either decode source, stall_front and bubble_ex are both 1 in the same cycle.
- R8: A producer in decode/execute that is not a load never raises stall_front or bubble_ex. A match between a decode source and the memory/writeback destination raises neither, because the split-cycle register file covers it.
- R9: A load whose destination is register 0, or that matches neither decode source, raises neither stall_front nor bubble_ex. The two signals are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_a | input | REG_AW | First source register of the instruction in decode |
| id_src_b | input | REG_AW | Second source register of the instruction in decode |
| ex_src_a | input | REG_AW | First source register of the instruction in execute |
| ex_src_b | input | REG_AW | Second source register of the instruction in execute |
| ex_dst | input | REG_AW | Destination held in decode/execute |
| ex_is_load | input | 1 | Decode/execute holds a load |
| mem_dst | input | REG_AW | Destination held in execute/memory |
| mem_wr_en | input | 1 | Register write enable held in execute/memory |
| wb_dst | input | REG_AW | Destination held in memory/writeback |
| wb_wr_en | input | 1 | Register write enable held in memory/writeback |
| fwd_sel_a | output | 2 | Select for ALU operand A: 00 register file, 10 execute/memory, 01 writeback |
| fwd_sel_b | output | 2 | Select for ALU operand B, same encoding |
| stall_front | output | 1 | Hold the PC and the fetch/decode register |
| bubble_ex | output | 1 | Load a bubble into decode/execute |

## Verification
The bench builds the unit with the default 5-bit register numbers. Random register numbers are drawn from only the low four values. This makes matches, double matches and register-0 cases common, while the full width is still covered by directed cases that use register 31. A few directed vectors cover the priority case, the disabled-writer case and the register-0 load before the random phase starts.

// File: rtl/hazard_fwd_pkg.sv
package hazard_fwd_pkg;

    // Operand source select for one ALU input.
    typedef enum logic [1:0] {
        SEL_REGFILE = 2'b00,
        SEL_WB      = 2'b01,
        SEL_MEM     = 2'b10
    } fwd_sel_e;

endpackage

// File: rtl/fwd_src_match.sv
module fwd_src_match
    import hazard_fwd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] mem_dst,
    input  logic              mem_wr_en,
    input  logic [REG_AW-1:0] wb_dst,
    input  logic              wb_wr_en,
    output fwd_sel_e          sel
);

    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic src_live;
    logic hit_mem;
    logic hit_wb;

    // Register 0 is hardwired to zero, so it is never a bypass candidate.
    assign src_live = (src != ZERO_REG);
    assign hit_mem  = src_live && mem_wr_en && (mem_dst == src);
    assign hit_wb   = src_live && wb_wr_en  && (wb_dst  == src);

    // The younger result (execute/memory) takes priority over writeback.
    always_comb begin
        if (hit_mem)
            sel = SEL_MEM;
        else if (hit_wb)
            sel = SEL_WB;
        else
            sel = SEL_REGFILE;
    end

endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
    parameter int REG_AW = 5,
    parameter int NSRC   = 2
) (
    input  logic [NSRC-1:0][REG_AW-1:0] id_src,
    input  logic [REG_AW-1:0]           ex_dst,
    input  logic                        ex_is_load,
    output logic                        hazard
);

    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic [NSRC-1:0] src_hit;

    genvar gi;
    generate
        for (gi = 0; gi < NSRC; gi++) begin : g_cmp
            assign src_hit[gi] = (id_src[gi] == ex_dst);
        end
    endgenerate

    // A load's data is ready only after memory. A consumer right behind it
    // therefore has to wait one cycle before the writeback bypass can serve it.
    assign hazard = ex_is_load && (ex_dst != ZERO_REG) && (|src_hit);

endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
    import hazard_fwd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] id_src_a,
    input  logic [REG_AW-1:0] id_src_b,
    input  logic [REG_AW-1:0] ex_src_a,
    input  logic [REG_AW-1:0] ex_src_b,
    input  logic [REG_AW-1:0] ex_dst,
    input  logic              ex_is_load,
    input  logic [REG_AW-1:0] mem_dst,
    input  logic              mem_wr_en,
    input  logic [REG_AW-1:0] wb_dst,
    input  logic              wb_wr_en,
    output logic [1:0]        fwd_sel_a,
    output logic [1:0]        fwd_sel_b,
    output logic              stall_front,
    output logic              bubble_ex
);

    localparam int NSRC = 2;

    logic [NSRC-1:0][REG_AW-1:0] ex_src;
    logic [NSRC-1:0][REG_AW-1:0] id_src;
    fwd_sel_e                    op_sel [NSRC];
    logic                        load_hazard;

    assign ex_src[0] = ex_src_a;
    assign ex_src[1] = ex_src_b;
    assign id_src[0] = id_src_a;
    assign id_src[1] = id_src_b;

    genvar gi;
    generate
        for (gi = 0; gi < NSRC; gi++) begin : g_operand
            fwd_src_match #(
                .REG_AW (REG_AW)
            ) u_match (
                .src       (ex_src[gi]),
                .mem_dst   (mem_dst),
                .mem_wr_en (mem_wr_en),
                .wb_dst    (wb_dst),
                .wb_wr_en  (wb_wr_en),
                .sel       (op_sel[gi])
            );
        end
    endgenerate

    load_use_detect #(
        .REG_AW (REG_AW),
        .NSRC   (NSRC)
    ) u_load_use (
        .id_src     (id_src),
        .ex_dst     (ex_dst),
        .ex_is_load (ex_is_load),
        .hazard     (load_hazard)
    );

    assign fwd_sel_a   = op_sel[0];
    assign fwd_sel_b   = op_sel[1];
    assign stall_front = load_hazard;
    assign bubble_ex   = load_hazard;

endmodule

// File: rtl/hazard_fwd_unit_chk.sv
module hazard_fwd_unit_chk #(
    parameter int REG_AW = 5
) (
    input logic [REG_AW-1:0] id_src_a,
    input logic [REG_AW-1:0] id_src_b,
    input logic [REG_AW-1:0] ex_src_a,
    input logic [REG_AW-1:0] ex_src_b,
    input logic [REG_AW-1:0] ex_dst,
    input logic              ex_is_load,
    input logic [REG_AW-1:0] mem_dst,
    input logic              mem_wr_en,
    input logic [REG_AW-1:0] wb_dst,
    input logic              wb_wr_en,
    input logic [1:0]        fwd_sel_a,
    input logic [1:0]        fwd_sel_b,
    input logic              stall_front,
    input logic              bubble_ex
);

    always_comb begin
        AST_SEL_LEGAL_A: assert (fwd_sel_a != 2'b11) else $error("illegal select A"); // R6
        AST_SEL_LEGAL_B: assert (fwd_sel_b != 2'b11) else $error("illegal select B"); // R6
        AST_MEM_SRC_A: assert (fwd_sel_a != 2'b10 || (mem_wr_en && mem_dst == ex_src_a)) else $error("A mem select without enabled match"); // R1
        AST_MEM_SRC_B: assert (fwd_sel_b != 2'b10 || (mem_wr_en && mem_dst == ex_src_b)) else $error("B mem select without enabled match"); // R1
        AST_WB_SRC_A: assert (fwd_sel_a != 2'b01 || (wb_wr_en && wb_dst == ex_src_a && !(mem_wr_en && mem_dst == ex_src_a))) else $error("A writeback select wrong"); // R3
        AST_WB_SRC_B: assert (fwd_sel_b != 2'b01 || (wb_wr_en && wb_dst == ex_src_b && !(mem_wr_en && mem_dst == ex_src_b))) else $error("B writeback select wrong"); // R2
        AST_ZERO_REG_A: assert (ex_src_a != '0 || fwd_sel_a == 2'b00) else $error("register 0 bypassed on A"); // R4
        AST_ZERO_REG_B: assert (ex_src_b != '0 || fwd_sel_b == 2'b00) else $error("register 0 bypassed on B"); // R4
        AST_STALL_NEEDS_LOAD: assert (!stall_front || (ex_is_load && ex_dst != '0)) else $error("stall without nonzero load"); // R8
        AST_STALL_BUBBLE_PAIR: assert (stall_front == bubble_ex) else $error("stall and bubble differ"); // R9
        AST_LOAD_USE_STALL: assert (!(ex_is_load && ex_dst != '0 && (ex_dst == id_src_a || ex_dst == id_src_b)) || stall_front) else $error("missed load-use"); // R7
    end

endmodule

bind hazard_fwd_unit hazard_fwd_unit_chk #(
    .REG_AW (REG_AW)
) u_chk (
    .id_src_a    (id_src_a),
    .id_src_b    (id_src_b),
    .ex_src_a    (ex_src_a),
    .ex_src_b    (ex_src_b),
    .ex_dst      (ex_dst),
    .ex_is_load  (ex_is_load),
    .mem_dst     (mem_dst),
    .mem_wr_en   (mem_wr_en),
    .wb_dst      (wb_dst),
    .wb_wr_en    (wb_wr_en),
    .fwd_sel_a   (fwd_sel_a),
    .fwd_sel_b   (fwd_sel_b),
    .stall_front (stall_front),
    .bubble_ex   (bubble_ex)
);

// File: tb/hazard_fwd_unit_bench.sv
module hazard_fwd_unit_bench;

    localparam int AW = 5;

    logic          clk = 1'b0;
    logic [AW-1:0] id_src_a, id_src_b, ex_src_a, ex_src_b, ex_dst, mem_dst, wb_dst;
    logic          ex_is_load, mem_wr_en, wb_wr_en;
    logic [1:0]    fwd_sel_a, fwd_sel_b;
    logic          stall_front, bubble_ex;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    hazard_fwd_unit #(.REG_AW(AW)) u_hazard_fwd_unit (
        .id_src_a    (id_src_a),
        .id_src_b    (id_src_b),
        .ex_src_a    (ex_src_a),
        .ex_src_b    (ex_src_b),
        .ex_dst      (ex_dst),
        .ex_is_load  (ex_is_load),
        .mem_dst     (mem_dst),
        .mem_wr_en   (mem_wr_en),
        .wb_dst      (wb_dst),
        .wb_wr_en    (wb_wr_en),
        .fwd_sel_a   (fwd_sel_a),
        .fwd_sel_b   (fwd_sel_b),
        .stall_front (stall_front),
        .bubble_ex   (bubble_ex)
    );

    function automatic logic [1:0] exp_sel(logic [AW-1:0] s, logic [AW-1:0] md, logic mw,
                                           logic [AW-1:0] wd, logic ww);
        if (s != 0 && mw && md == s) return 2'b10;
        if (s != 0 && ww && wd == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic exp_stall(logic [AW-1:0] a, logic [AW-1:0] b,
                                       logic [AW-1:0] d, logic ld);
        return ld && d != 0 && (d == a || d == b);
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic apply(logic [AW-1:0] ia, logic [AW-1:0] ib, logic [AW-1:0] ea,
                         logic [AW-1:0] eb, logic [AW-1:0] ed, logic ld,
                         logic [AW-1:0] md, logic mw, logic [AW-1:0] wd, logic ww);
        @(posedge clk);
        #1;
        id_src_a = ia; id_src_b = ib; ex_src_a = ea; ex_src_b = eb;
        ex_dst = ed; ex_is_load = ld; mem_dst = md; mem_wr_en = mw;
        wb_dst = wd; wb_wr_en = ww;
        @(negedge clk);
    endtask

    task automatic check_all(string tag);
        check({tag, " sel_a"}, {6'd0, fwd_sel_a},
              {6'd0, exp_sel(ex_src_a, mem_dst, mem_wr_en, wb_dst, wb_wr_en)});
        check({tag, " sel_b"}, {6'd0, fwd_sel_b},
              {6'd0, exp_sel(ex_src_b, mem_dst, mem_wr_en, wb_dst, wb_wr_en)});
        check({tag, " stall"}, {7'd0, stall_front},
              {7'd0, exp_stall(id_src_a, id_src_b, ex_dst, ex_is_load)});
        check({tag, " bubble"}, {7'd0, bubble_ex},
              {7'd0, exp_stall(id_src_a, id_src_b, ex_dst, ex_is_load)});
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // Quiet state: nothing enabled, selects and stall at zero (R6)
        apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R6 idle sel_a", {6'd0, fwd_sel_a}, 8'h00);
        check("R6 idle stall", {7'd0, stall_front}, 8'h00);

        // R1: operand A matches execute/memory
        apply(1, 2, 3, 4, 9, 0, 3, 1, 7, 1);
        check("R1 mem bypass A", {6'd0, fwd_sel_a}, 8'h02);
        check("R6 no match B", {6'd0, fwd_sel_b}, 8'h00);

        // R2: operand B matches writeback only
        apply(1, 2, 3, 31, 9, 0, 5, 1, 31, 1);
        check("R2 wb bypass B", {6'd0, fwd_sel_b}, 8'h01);

        // R3: both stages match the same source
        apply(1, 2, 6, 6, 9, 0, 6, 1, 6, 1);
        check("R3 priority A", {6'd0, fwd_sel_a}, 8'h02);
        check("R3 priority B", {6'd0, fwd_sel_b}, 8'h02);

        // R4: register 0 never bypassed
        apply(0, 0, 0, 0, 0, 1, 0, 1, 0, 1);
        check("R4 zero src A", {6'd0, fwd_sel_a}, 8'h00);
        check("R4 zero src B", {6'd0, fwd_sel_b}, 8'h00);

        // R5: disabled writers ignored
        apply(1, 2, 8, 8, 9, 0, 8, 0, 8, 0);
        check("R5 disabled A", {6'd0, fwd_sel_a}, 8'h00);
        apply(1, 2, 8, 8, 9, 0, 8, 0, 8, 1);
        check("R5 mem disabled wb used", {6'd0, fwd_sel_a}, 8'h01);

        // R7: load-use on each decode source
        apply(12, 3, 1, 1, 12, 1, 0, 0, 0, 0);
        check("R7 load-use src A stall", {7'd0, stall_front}, 8'h01);
        check("R7 load-use src A bubble", {7'd0, bubble_ex}, 8'h01);
        apply(3, 31, 1, 1, 31, 1, 0, 0, 0, 0);
        check("R7 load-use src B stall", {7'd0, stall_front}, 8'h01);

        // R8: ALU producer and writeback match do not stall
        apply(12, 3, 1, 1, 12, 0, 0, 0, 12, 1);
        check("R8 alu producer stall", {7'd0, stall_front}, 8'h00);
        check("R8 alu producer bubble", {7'd0, bubble_ex}, 8'h00);

        // R9: load to register 0, and load with no consumer
        apply(0, 0, 1, 1, 0, 1, 0, 0, 0, 0);
        check("R9 load r0 stall", {7'd0, stall_front}, 8'h00);
        apply(4, 5, 1, 1, 6, 1, 0, 0, 0, 0);
        check("R9 load no match bubble", {7'd0, bubble_ex}, 8'h00);

        // Random phase over R1 to R9 behaviour, small register range
        void'($urandom(32'd20240611));
        for (int i = 0; i < 1500; i++) begin
            apply(AW'($urandom % 4), AW'($urandom % 4), AW'($urandom % 4),
                  AW'($urandom % 4), AW'($urandom % 4), 1'($urandom),
                  AW'($urandom % 4), 1'($urandom), AW'($urandom % 4), 1'($urandom));
            check_all("R1/R2/R3/R4/R5/R6/R7/R8/R9 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule